// File: doc/BRIEF.md
# Shared Issue-Queue Slot Governor

This block keeps the occupancy books for an instruction-queue pool shared by several hardware threads and decides, each cycle, which threads may place a new entry into it. It does not store instructions and plays no part in wakeup or selection. It only counts slots and makes the admission decision.

Each thread's ceiling comes from a sharing policy chosen by a static input, together with the current mask of active threads. Under the shared policy every thread may use the whole pool. Under the split policy the pool is divided evenly among the active threads. Under the capped policy each thread may use a fixed percentage of the pool, unless only one thread is active.

Releases are applied before admission is decided. Any slot released in a cycle can therefore be granted again in that same cycle. Grants themselves are combinational and are returned in the same cycle as the request. The occupancy counters and the free count update at the next clock edge.

Top module: `iq_slot_governor`

## Requirements
- R1: After reset, the free count equals the pool size (POOL, default 16), every occupancy is zero and every full flag is low.
- R2: With policy code 0 (shared) or code 3, each thread's limit is POOL.
- R3: With policy code 1 (split), each thread's limit is floor(POOL / n), where n is the number of set bits in the active mask. When no bit is set, n is taken as NUM_THR.
- R4: With policy code 2 (capped), each thread's limit is floor(POOL * CAP_PCT / 100), with CAP_PCT defaulting to 50. When exactly one bit of the active mask is set, the limit is POOL.
- R5: A requesting thread is granted when its post-release occupancy is below the limit and a free slot remains after the grants to lower-numbered threads in the same cycle. Lower thread numbers take priority.
- R6: A request that is not granted changes neither the thread's occupancy nor the free count.
- R7: A release pulse lowers the thread's occupancy by the release count and raises the free count by the same amount. The count is clamped to the thread's current occupancy.
- R8: A thread sitting at its limit that releases and requests in the same cycle is granted in that cycle.
- R9: A thread's full flag is high when its occupancy is at or above the current limit, or when the free count is zero.
- R10: The free count always equals POOL minus the sum of all occupancies. It falls by one for each grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Sharing policy code: 0 shared, 1 split, 2 capped, 3 shared |
| act_mask | input | NUM_THR | Active-thread mask |
| ins_req | input | NUM_THR | Per-thread request to insert one entry |
| ins_grant | output | NUM_THR | Per-thread insert accepted, returned in the same cycle |
| rel_vld | input | NUM_THR | Per-thread release pulse (issue or squash) |
| rel_cnt | input | NUM_THR x CW | Per-thread number of entries released |
| thr_full | output | NUM_THR | Per-thread full flag |
| free_cnt | output | CW | Free entries in the pool |

## Verification
The critical overlap is a release and an insert on the same thread in the same cycle. Its counterpart is a release on one thread landing in the cycle another thread requests into an empty pool. The bench provokes the first directly: it fills a thread to its split limit, then pulses a one-entry release alongside a request, and expects a grant with the free count unchanged. Randomised phases mix releases of zero to two entries with requests on every thread under each policy and mask. A bench model applies releases first and grants second, and every grant, full flag and free count is judged against that model.

// File: rtl/iqg_pkg.sv
package iqg_pkg;
    typedef enum logic [1:0] {
        POL_SHARED = 2'd0,
        POL_SPLIT  = 2'd1,
        POL_CAP    = 2'd2,
        POL_RSVD   = 2'd3
    } share_pol_e;
endpackage

// File: rtl/iqg_limit_calc.sv
module iqg_limit_calc
    import iqg_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int POOL    = 16,
    parameter int CAP_PCT = 50,
    parameter int CW      = $clog2(POOL + 1)
) (
    input  logic [1:0]         policy,
    input  logic [NUM_THR-1:0] act_mask,
    output logic [CW-1:0]      limit
);
    localparam int CAP_LIM = (POOL * CAP_PCT) / 100;
    localparam int NW      = $clog2(NUM_THR + 1);

    logic [NW-1:0] n_act;
    logic [CW-1:0] split_lim;

    // Split divisor is the live active count; each quotient is a constant.
    always_comb begin
        n_act     = NW'($countones(act_mask));
        split_lim = CW'(POOL / NUM_THR);
        for (int k = 1; k <= NUM_THR; k++) begin
            if (n_act == NW'(k)) split_lim = CW'(POOL / k);
        end
    end

    always_comb begin
        case (share_pol_e'(policy))
            POL_SPLIT: limit = split_lim;
            POL_CAP:   limit = (n_act == NW'(1)) ? CW'(POOL) : CW'(CAP_LIM);
            default:   limit = CW'(POOL);
        endcase
    end
endmodule

// File: rtl/iqg_admit.sv
module iqg_admit #(
    parameter int NUM_THR = 4,
    parameter int CW      = 5
) (
    input  logic [NUM_THR-1:0]         req,
    input  logic [NUM_THR-1:0][CW-1:0] occ_rel,
    input  logic [CW-1:0]              limit,
    input  logic [CW-1:0]              free_rel,
    output logic [NUM_THR-1:0]         grant
);
    logic [CW-1:0] taken;

    // Fixed priority: lower thread numbers claim free slots first.
    always_comb begin
        taken = '0;
        grant = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (req[t] && (occ_rel[t] < limit) && (free_rel > taken)) begin
                grant[t] = 1'b1;
                taken    = taken + CW'(1);
            end
        end
    end
endmodule

// File: rtl/iq_slot_governor.sv
module iq_slot_governor #(
    parameter int NUM_THR = 4,
    parameter int POOL    = 16,
    parameter int CAP_PCT = 50,
    parameter int CW      = $clog2(POOL + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 policy,
    input  logic [NUM_THR-1:0]         act_mask,
    input  logic [NUM_THR-1:0]         ins_req,
    output logic [NUM_THR-1:0]         ins_grant,
    input  logic [NUM_THR-1:0]         rel_vld,
    input  logic [NUM_THR-1:0][CW-1:0] rel_cnt,
    output logic [NUM_THR-1:0]         thr_full,
    output logic [CW-1:0]              free_cnt
);
    typedef struct packed {
        logic [NUM_THR-1:0][CW-1:0] occ;
        logic [CW-1:0]              free;
    } slot_st_t;

    slot_st_t st_d, st_q;

    logic [CW-1:0]              limit;
    logic [NUM_THR-1:0][CW-1:0] occ_rel_d;
    logic [CW-1:0]              free_rel_d;
    logic [CW+1:0]              occ_total;

    iqg_limit_calc #(
        .NUM_THR(NUM_THR), .POOL(POOL), .CAP_PCT(CAP_PCT), .CW(CW)
    ) u_limit (
        .policy(policy), .act_mask(act_mask), .limit(limit)
    );

    // Releases land first, clamped to what the thread holds.
    always_comb begin
        logic [CW-1:0] take;
        free_rel_d = st_q.free;
        for (int t = 0; t < NUM_THR; t++) begin
            take = '0;
            if (rel_vld[t])
                take = (rel_cnt[t] > st_q.occ[t]) ? st_q.occ[t] : rel_cnt[t];
            occ_rel_d[t] = st_q.occ[t] - take;
            free_rel_d   = free_rel_d + take;
        end
    end

    iqg_admit #(.NUM_THR(NUM_THR), .CW(CW)) u_admit (
        .req(ins_req), .occ_rel(occ_rel_d), .limit(limit),
        .free_rel(free_rel_d), .grant(ins_grant)
    );

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NUM_THR; t++)
            st_d.occ[t] = occ_rel_d[t] + CW'(ins_grant[t]);
        st_d.free = free_rel_d - CW'($countones(ins_grant));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.occ  <= '0;
            st_q.free <= CW'(POOL);
        end else begin
            st_q <= st_d;
        end
    end

    assign free_cnt = st_q.free;

    genvar g;
    generate
        for (g = 0; g < NUM_THR; g++) begin : g_thr
            assign thr_full[g] = (st_q.occ[g] >= limit) || (st_q.free == '0);

            AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                (thr_full[g] && (rel_vld == '0)) |-> !ins_grant[g]); // R9
            AST_GRANT_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
                (ins_grant[g] && !rel_vld[g]) |=> (st_q.occ[g] == $past(st_q.occ[g]) + CW'(1))); // R5
            AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!ins_grant[g] && !rel_vld[g]) |=> (st_q.occ[g] == $past(st_q.occ[g]))); // R6
        end
    endgenerate

    always_comb begin
        occ_total = '0;
        for (int t = 0; t < NUM_THR; t++) occ_total = occ_total + (CW+2)'(st_q.occ[t]);
    end

    AST_FREE_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_total + (CW+2)'(st_q.free)) == (CW+2)'(POOL)); // R10
    AST_EMPTY_POOL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.free == '0) && (rel_vld == '0)) |-> (ins_grant == '0)); // R5
endmodule

// File: tb/iq_slot_governor_tb.sv
module iq_slot_governor_tb;
    localparam int NT   = 4;
    localparam int POOL = 16;
    localparam int PCT  = 50;
    localparam int CW   = $clog2(POOL + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            policy = '0;
    logic [NT-1:0]         act_mask = '0;
    logic [NT-1:0]         ins_req = '0;
    logic [NT-1:0]         ins_grant;
    logic [NT-1:0]         rel_vld = '0;
    logic [NT-1:0][CW-1:0] rel_cnt = '0;
    logic [NT-1:0]         thr_full;
    logic [CW-1:0]         free_cnt;

    int n_chk = 0, n_bad = 0;
    int m_occ [NT];
    int m_free;
    logic [NT-1:0] last_g;
    bit done = 0;

    always #10 clk = ~clk;

    iq_slot_governor #(.NUM_THR(NT), .POOL(POOL), .CAP_PCT(PCT)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .act_mask(act_mask),
        .ins_req(ins_req), .ins_grant(ins_grant), .rel_vld(rel_vld),
        .rel_cnt(rel_cnt), .thr_full(thr_full), .free_cnt(free_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lim(input int pol, input logic [NT-1:0] mask);
        int n = $countones(mask);
        case (pol)
            1: return POOL / ((n == 0) ? NT : n);
            2: return (n == 1) ? POOL : (POOL * PCT) / 100;
            default: return POOL;
        endcase
    endfunction

    task automatic check_state();
        int l = exp_lim(int'(policy), act_mask);
        chk("R10 free count", int'(free_cnt), m_free);
        for (int t = 0; t < NT; t++)
            chk("R9 full flag", int'(thr_full[t]), int'((m_occ[t] >= l) || (m_free == 0)));
    endtask

    task automatic cyc(input logic [1:0] pol, input logic [NT-1:0] mask,
                       input logic [NT-1:0] req, input logic [NT-1:0] rv,
                       input logic [NT-1:0][CW-1:0] rc);
        int occ_rel [NT];
        int free_rel, taken, l, tk;
        logic [NT-1:0] eg;
        @(negedge clk);
        check_state();
        policy = pol; act_mask = mask; ins_req = req; rel_vld = rv; rel_cnt = rc;
        #1;
        l = exp_lim(int'(pol), mask);
        free_rel = m_free;
        for (int t = 0; t < NT; t++) begin
            tk = 0;
            if (rv[t]) tk = (int'(rc[t]) > m_occ[t]) ? m_occ[t] : int'(rc[t]);
            occ_rel[t] = m_occ[t] - tk;
            free_rel  += tk;
        end
        taken = 0; eg = '0;
        for (int t = 0; t < NT; t++)
            if (req[t] && occ_rel[t] < l && free_rel - taken > 0) begin
                eg[t] = 1'b1; taken++;
            end
        chk("R5 grant vector", int'(ins_grant), int'(eg));
        last_g = ins_grant;
        for (int t = 0; t < NT; t++) m_occ[t] = occ_rel[t] + int'(eg[t]);
        m_free = free_rel - taken;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NT-1:0][CW-1:0] rc_max, rc_one, rc_zero, rc_rand;
        int got, fv;
        string ptag;
        for (int t = 0; t < NT; t++) begin
            rc_max[t] = '1; rc_one[t] = CW'(1); rc_zero[t] = '0;
            m_occ[t] = 0;
        end
        m_free = POOL;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset free count", int'(free_cnt), POOL);
        chk("R1 reset full flags", int'(thr_full), 0);

        // Directed: split policy, two active, limit 8.
        for (int i = 0; i < 8; i++) cyc(2'd1, 4'b0011, 4'b0001, '0, rc_zero);
        cyc(2'd1, 4'b0011, 4'b0001, 4'b0001, rc_one);
        chk("R8 release and insert same cycle", int'(last_g[0]), 1);
        fv = m_free;
        cyc(2'd1, 4'b0011, 4'b0001, '0, rc_zero);
        chk("R6 request at limit rejected", int'(last_g[0]), 0);
        @(negedge clk);
        chk("R6 rejected request leaves free count", int'(free_cnt), fv);
        cyc(2'd1, 4'b0011, '0, 4'b0001, rc_max);
        @(negedge clk);
        chk("R7 clamped release restores pool", int'(free_cnt), POOL);

        // Sweep every policy code and active mask.
        for (int p = 0; p < 4; p++) begin
            ptag = (p == 1) ? "R3 split limit" : (p == 2) ? "R4 capped limit" : "R2 shared limit";
            for (int m = 1; m < 16; m++) begin
                cyc(p[1:0], m[NT-1:0], '0, '1, rc_max);
                got = 0;
                for (int i = 0; i < 20; i++) begin
                    cyc(p[1:0], m[NT-1:0], 4'b0001, '0, rc_zero);
                    got += int'(last_g[0]);
                end
                chk(ptag, got, exp_lim(p, m[NT-1:0]));
                for (int i = 0; i < 30; i++) begin
                    for (int t = 0; t < NT; t++) rc_rand[t] = CW'($urandom_range(0, 2));
                    cyc(p[1:0], m[NT-1:0], NT'($urandom), NT'($urandom), rc_rand);
                end
            end
        end
        cyc(2'd1, 4'b0000, 4'b1111, '0, rc_zero);
        @(negedge clk);
        check_state();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule